// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects thirteen event flags for a network MAC into one 32-bit event word, holds a 32-bit enable word beside it, and routes each enabled event to its own interrupt line. Event sources elsewhere in the MAC raise single-cycle set pulses, one per line. Software reads both words through a small register port. It acknowledges events by writing ones to the event word at the positions it wants cleared.

Each of the thirteen lines has a fixed event bit in the upper part of the event word. The lower nineteen bits carry no event. A line stays high for as long as its event bit and the matching enable bit are both 1, so the interrupt controller upstream sees level-sensitive requests. Each line comes out of a register.

Top module: `irq_event_ctrl`

## Requirements
- R1: While reset is held, and right after it, the event word and the enable word read 0 and every interrupt line is low.
- R2: A pulse on set_pulse[i] sets one event bit, whose position depends on i as follows: i=0 bit 27 (transmit frame), 1 bit 26 (transmit buffer), 2 bit 19 (underrun), 3 bit 20 (retry limit), 4 bit 25 (receive frame), 5 bit 24 (receive buffer), 6 bit 23 (management done), 7 bit 21 (late collision), 8 bit 31 (heartbeat), 9 bit 28 (graceful stop), 10 bit 22 (bus error), 11 bit 29 (babbling transmit), 12 bit 30 (babbling receive). The bit reads back as 1 in the cycle after the pulse.
- R3: A write to byte offset 0x004 clears each event bit whose written value is 1 and leaves every other event bit unchanged.
- R4: A write to byte offset 0x008 replaces all 32 bits of the enable word, and those bits read back exactly as written.
- R5: irq_lines[i] is 1 exactly when the event bit of R2 for line i and the enable bit at that same position are both 1. The line follows a change of either bit one clock later.
- R6: When a set pulse and a clearing write hit the same event bit in one cycle, the bit ends up set.
- R7: Event bits 18 down to 0 always read 0, and no write can set any event bit.
- R8: Reads at any offset other than 0x004 and 0x008 return 0, and writes there change neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| set_pulse | input | 13 | Per-line event set pulses, in line order |
| irq_lines | output | 13 | Per-line level interrupt requests |

## Verification
The checker takes for granted that reset is held low across the first clock edges. It also assumes every set pulse and every write strobe lasts exactly one sampled cycle, so that each stimulus maps to a single next-cycle outcome. The bench drives all inputs on the falling clock edge and releases them one cycle later. It never holds a strobe across two rising edges. Pulses that overlap clearing writes are applied on purpose, to exercise the set-over-clear rule.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

   localparam int EVT_LINES = 13;
   localparam int EVT_WORD_W = 32;

   // Event word bit position served by each interrupt line.
   function automatic int line_bit(input int idx);
      case (idx)
         0:       return 27;
         1:       return 26;
         2:       return 19;
         3:       return 20;
         4:       return 25;
         5:       return 24;
         6:       return 23;
         7:       return 21;
         8:       return 31;
         9:       return 28;
         10:      return 22;
         11:      return 29;
         12:      return 30;
         default: return 0;
      endcase
   endfunction

   // Bits of the event word that carry an event.
   function automatic logic [EVT_WORD_W-1:0] live_bits();
      logic [EVT_WORD_W-1:0] acc;
      acc = '0;
      for (int k = 0; k < EVT_LINES; k++) acc[line_bit(k)] = 1'b1;
      return acc;
   endfunction

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
   parameter int LINES = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] set_l,
   input  logic             clr_we,
   input  logic [LINES-1:0] clr_l,
   output logic [LINES-1:0] evt_l
);

   for (genvar i = 0; i < LINES; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   bit_q <= 1'b0;
         else if (set_l[i])            bit_q <= 1'b1;
         else if (clr_we && clr_l[i])  bit_q <= 1'b0;
      end
      assign evt_l[i] = bit_q;
   end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '0;
      else if (we) mask_q <= wdata;
   end

endmodule

// File: rtl/irq_line_route.sv
module irq_line_route #(
   parameter int LINES   = 13,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] evt_l,
   input  logic [LINES-1:0] en_l,
   output logic [LINES-1:0] lines
);

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic hit;
      assign hit = evt_l[i] & en_l[i];
      if (OUT_REG) begin : g_reg
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= hit;
         end
         assign lines[i] = line_q;
      end else begin : g_comb
         assign lines[i] = hit;
      end
   end

endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
   parameter int             ADDR_W  = 10,
   parameter int             DATA_W  = 32,
   parameter int             LINES   = 13,
   parameter logic [9:0]     EVT_OFS = 10'h004,
   parameter logic [9:0]     MSK_OFS = 10'h008,
   parameter bit             OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  set_pulse,
   output logic [LINES-1:0]  irq_lines
);

   localparam logic [ADDR_W-1:0] EVT_A = ADDR_W'(EVT_OFS);
   localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);

   if (LINES != irq_evt_pkg::EVT_LINES) begin : g_bad_lines
      $error("LINES must equal the routed event count");
   end
   if (DATA_W < irq_evt_pkg::EVT_WORD_W) begin : g_bad_width
      $error("DATA_W too narrow for the event word");
   end
   if (EVT_OFS == MSK_OFS || EVT_OFS[1:0] != 2'b00 || MSK_OFS[1:0] != 2'b00) begin : g_bad_ofs
      $error("register offsets must be distinct and word aligned");
   end

   logic              hit_evt, hit_msk;
   logic [LINES-1:0]  clr_l, evt_l, en_l;
   logic [DATA_W-1:0] evt_word, mask_q;

   assign hit_evt = (bus_addr == EVT_A);
   assign hit_msk = (bus_addr == MSK_A);

   for (genvar i = 0; i < LINES; i++) begin : g_map
      localparam int B = irq_evt_pkg::line_bit(i);
      assign clr_l[i] = bus_wdata[B];
      assign en_l[i]  = mask_q[B];
   end

   always_comb begin
      evt_word = '0;
      for (int i = 0; i < LINES; i++) evt_word[irq_evt_pkg::line_bit(i)] = evt_l[i];
   end

   irq_evt_latch #(.LINES(LINES)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_l  (set_pulse),
      .clr_we (bus_wr & hit_evt),
      .clr_l  (clr_l),
      .evt_l  (evt_l)
   );

   irq_mask_reg #(.WIDTH(DATA_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_wr & hit_msk),
      .wdata  (bus_wdata),
      .mask_q (mask_q)
   );

   irq_line_route #(.LINES(LINES), .OUT_REG(OUT_REG)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_l  (evt_l),
      .en_l   (en_l),
      .lines  (irq_lines)
   );

   always_comb begin
      if (hit_evt)      bus_rdata = evt_word;
      else if (hit_msk) bus_rdata = mask_q;
      else              bus_rdata = '0;
   end

endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk #(
   parameter int         ADDR_W  = 10,
   parameter int         DATA_W  = 32,
   parameter int         LINES   = 13,
   parameter logic [9:0] EVT_OFS = 10'h004,
   parameter logic [9:0] MSK_OFS = 10'h008
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [LINES-1:0]  set_pulse,
   input logic [LINES-1:0]  irq_lines,
   input logic [DATA_W-1:0] evt_word,
   input logic [DATA_W-1:0] mask_q
);

   localparam logic [ADDR_W-1:0] EVT_A = ADDR_W'(EVT_OFS);
   localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFS);
   localparam logic [31:0]       LIVE  = irq_evt_pkg::live_bits();

   for (genvar i = 0; i < LINES; i++) begin : g_chk
      localparam int B = irq_evt_pkg::line_bit(i);

      // R2 R6
      evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[i] |=> evt_word[B]);

      // R3
      evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == EVT_A && bus_wdata[B] && !set_pulse[i]) |=> !evt_word[B]);

      // R3
      evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_pulse[i] && !(bus_wr && bus_addr == EVT_A && bus_wdata[B])) |=> $stable(evt_word[B]));

      // R5
      line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_lines[i] == $past(evt_word[B] & mask_q[B])));
   end

   // R4
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == MSK_A) |=> (mask_q == $past(bus_wdata)));

   // R7
   dead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == EVT_A) |-> ((bus_rdata[31:0] & ~LIVE) == 32'h0));

   // R8
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != EVT_A && bus_addr != MSK_A) |-> (bus_rdata == '0));

endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
   .EVT_OFS(EVT_OFS), .MSK_OFS(MSK_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .set_pulse (set_pulse),
   .irq_lines (irq_lines),
   .evt_word  (evt_word),
   .mask_q    (mask_q)
);

// File: tb/test_irq_event_ctrl.sv
`timescale 1ns/1ps
module test_irq_event_ctrl;

   localparam int NL = 13;
   localparam logic [9:0] A_EVT = 10'h004;
   localparam logic [9:0] A_MSK = 10'h008;
   localparam logic [9:0] A_OFF = 10'h00C;
   localparam int LMAP [NL] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

   typedef struct packed {
      logic [12:0] set;
      logic [1:0]  op;    // 0 none, 1 event write, 2 enable write, 3 unmapped write
      logic [31:0] data;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{13'h0001, 2'd0, 32'h0000_0000},   // R2 line 0
      '{13'h0000, 2'd2, 32'h0800_0000},   // R4 R5 enable line 0
      '{13'h1FFF, 2'd0, 32'h0000_0000},   // R2 all lines
      '{13'h0000, 2'd2, 32'hFFFF_FFFF},   // R4 R5
      '{13'h0000, 2'd1, 32'h0800_0000},   // R3 single clear
      '{13'h0000, 2'd1, 32'h0207_FFFF},   // R3 R7
      '{13'h0010, 2'd1, 32'h0200_0000},   // R6 set beats clear
      '{13'h0000, 2'd2, 32'h5555_0000},   // R4 R5 partial enable
      '{13'h0000, 2'd3, 32'hFFFF_FFFF},   // R8 unmapped write
      '{13'h0000, 2'd1, 32'hFFFF_FFFF}    // R3 clear all
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [12:0] set_pulse = '0;
   logic [12:0] irq_lines;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [31:0] m_evt = '0;
   logic [31:0] m_msk = '0;

   always #4 clk = ~clk;

   irq_event_ctrl i_irq_event_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .set_pulse(set_pulse), .irq_lines(irq_lines)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [12:0] exp_lines(input logic [31:0] e, input logic [31:0] m);
      logic [12:0] r;
      for (int i = 0; i < NL; i++) r[i] = e[LMAP[i]] & m[LMAP[i]];
      return r;
   endfunction

   function automatic logic [31:0] set_word(input logic [12:0] s);
      logic [31:0] w;
      w = '0;
      for (int i = 0; i < NL; i++) if (s[i]) w[LMAP[i]] = 1'b1;
      return w;
   endfunction

   task automatic read_reg(input logic [9:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      // R1 during reset
      repeat (2) @(negedge clk);
      read_reg(A_EVT, rd); chk("R1 events in reset", rd, 32'h0);
      chk("R1 lines in reset", {19'h0, irq_lines}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      read_reg(A_EVT, rd); chk("R1 events after reset", rd, 32'h0);
      read_reg(A_MSK, rd); chk("R1 enable after reset", rd, 32'h0);
      chk("R1 lines after reset", {19'h0, irq_lines}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         set_pulse = VECS[k].set;
         bus_wr    = (VECS[k].op != 2'd0);
         bus_wdata = VECS[k].data;
         bus_addr  = (VECS[k].op == 2'd1) ? A_EVT : (VECS[k].op == 2'd2) ? A_MSK : A_OFF;
         @(negedge clk);
         set_pulse = '0;
         bus_wr    = 1'b0;
         bus_wdata = '0;
         if (VECS[k].op == 2'd1) m_evt = m_evt & ~VECS[k].data;
         m_evt = m_evt | set_word(VECS[k].set);
         if (VECS[k].op == 2'd2) m_msk = VECS[k].data;
         @(negedge clk);
         read_reg(A_EVT, rd); chk("R2 R3 R6 R7 event word", rd, m_evt);
         read_reg(A_MSK, rd); chk("R4 R8 enable word", rd, m_msk);
         chk("R5 lines", {19'h0, irq_lines}, {19'h0, exp_lines(m_evt, m_msk)});
      end

      // R8 unmapped read
      read_reg(A_OFF, rd); chk("R8 unmapped read", rd, 32'h0);

      // R5 latency: line 3 (bit 20) with everything enabled
      bus_addr = A_MSK; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; set_pulse = 13'h0008;
      @(negedge clk);
      set_pulse = '0;
      read_reg(A_EVT, rd); chk("R2 line 3 sets bit 20", rd, 32'h0010_0000);
      chk("R5 line not yet high", {19'h0, irq_lines}, 32'h0);
      @(negedge clk);
      chk("R5 line high one cycle later", {19'h0, irq_lines}, 32'h0000_0008);

      // R1 reset mid-run
      set_pulse = 13'h1FFF;
      @(negedge clk);
      set_pulse = '0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 lines cleared by reset", {19'h0, irq_lines}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_reg(A_EVT, rd); chk("R1 events cleared by reset", rd, 32'h0);
      read_reg(A_MSK, rd); chk("R1 enable cleared by reset", rd, 32'h0);

      finish_run();
   end

endmodule